// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits between the 16-bit address bus of an 8-bit game CPU and the memories and registers around it. From the address and the read and write strobes it raises one chip select per access: work RAM, sprite RAM, background RAM, five input ports, the horizontal and vertical scroll registers, the sound command latch, a control strobe, video RAM, palette RAM, a fixed ROM, and a paged ROM window. The memories, the registers behind these selects and the sound processor are not part of it.

A 4-bit page register picks which 36 KB slice of a large ROM shows through the window at 0x5000-0xDFFF. The CPU writes this register at 0x4008. The slice size is not a power of two, so each page starts at 0x10000 plus a multiple of 0x9000. The block therefore forms the 20-bit ROM address with a small multiply-add rather than by joining bits. The selects and the ROM address are combinational. The page register is the only state.

Top module: `paged_map_decoder`

## Requirements
- R1: After reset the page register is 0, so a read at 0x5000 gives rom_addr 0x10000.
- R2: A read at 0xE000-0xFFFF raises rom_fixed_cs. Whenever rom_bank_cs is low, rom_addr equals the CPU address zero-extended to 20 bits.
- R3: A read at 0x5000-0xDFFF raises rom_bank_cs, with rom_addr = 0x10000 + page*0x9000 + (address - 0x5000). Page 15 at 0xDFFF gives 0x9FFFF.
- R4: A write at 0x4008 loads the page register from data bits 3:0 on that clock edge, ignoring bits 7:4. The new page takes effect from the next cycle, and no select is raised by this write.
- R5: A read at 0x4008+n for n = 0..4 sets bit n of port_rd_cs and no other bit.
- R6: A read at 0x0000-0x3FFF raises ram_rd_cs. A write raises work_wr_cs at 0x0000-0x1DFF, obj_wr_cs at 0x1E00-0x1FFF, and bg_wr_cs at 0x2000-0x3FFF.
- R7: Writes at 0x400A-0x400B raise hscroll_wr_cs, writes at 0x400C-0x400D raise vscroll_wr_cs, and a write at 0x400E raises sndcmd_wr_cs.
- R8: Writes at 0x5000-0x5FFF raise vram_wr_cs and writes at 0x7100-0x73FF raise pal_wr_cs. Writes at 0x7400-0xFFFF raise nothing.
- R9: A write at 0x4009 raises ctrl_pulse for that cycle.
- R10: At most one select is high in any cycle. None is high for an unmapped address, or when cpu_rd and cpu_wr are both high or both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| rom_addr | output | 20 | Extended ROM address |
| rom_fixed_cs | output | 1 | Fixed ROM read select |
| rom_bank_cs | output | 1 | Paged ROM window read select |
| ram_rd_cs | output | 1 | RAM read select |
| work_wr_cs | output | 1 | Work RAM write select |
| obj_wr_cs | output | 1 | Sprite RAM write select |
| bg_wr_cs | output | 1 | Background RAM write select |
| port_rd_cs | output | 5 | One-hot input port read select |
| hscroll_wr_cs | output | 1 | Horizontal scroll write select |
| vscroll_wr_cs | output | 1 | Vertical scroll write select |
| sndcmd_wr_cs | output | 1 | Sound command latch write select |
| ctrl_pulse | output | 1 | Control write strobe |
| vram_wr_cs | output | 1 | Video RAM write select |
| pal_wr_cs | output | 1 | Palette RAM write select |

## Verification
The assertions take for granted that the address, data and strobes are steady around each rising edge. They also assume that a page write is sampled on exactly the edge where the strobe is seen. The stimulus changes every input only on the falling edge. Each cycle it mixes corner addresses at the ends of each region with fully random addresses, and it sometimes drives both strobes or neither, so the illegal strobe combinations are exercised too.

// File: rtl/paged_map_decoder.sv
module paged_map_decoder #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int PW          = 4,
  parameter int RW          = 20,
  parameter int NPORT       = 5,
  parameter int BANK_BASE   = 32'h10000,
  parameter int BANK_STRIDE = 32'h9000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  output logic [RW-1:0]    rom_addr,
  output logic             rom_fixed_cs,
  output logic             rom_bank_cs,
  output logic             ram_rd_cs,
  output logic             work_wr_cs,
  output logic             obj_wr_cs,
  output logic             bg_wr_cs,
  output logic [NPORT-1:0] port_rd_cs,
  output logic             hscroll_wr_cs,
  output logic             vscroll_wr_cs,
  output logic             sndcmd_wr_cs,
  output logic             ctrl_pulse,
  output logic             vram_wr_cs,
  output logic             pal_wr_cs
);

  localparam logic [AW-1:0] RAM_TOP   = AW'(16'h3FFF);
  localparam logic [AW-1:0] WORK_TOP  = AW'(16'h1DFF);
  localparam logic [AW-1:0] OBJ_TOP   = AW'(16'h1FFF);
  localparam logic [AW-1:0] PAGE_REG  = AW'(16'h4008);
  localparam logic [AW-1:0] CTRL_REG  = AW'(16'h4009);
  localparam logic [AW-1:0] HS_LO     = AW'(16'h400A);
  localparam logic [AW-1:0] HS_HI     = AW'(16'h400B);
  localparam logic [AW-1:0] VS_LO     = AW'(16'h400C);
  localparam logic [AW-1:0] VS_HI     = AW'(16'h400D);
  localparam logic [AW-1:0] SND_REG   = AW'(16'h400E);
  localparam logic [AW-1:0] PORT_TOP  = PAGE_REG + AW'(NPORT - 1);
  localparam logic [AW-1:0] WIN_LO    = AW'(16'h5000);
  localparam logic [AW-1:0] WIN_HI    = AW'(16'hDFFF);
  localparam logic [AW-1:0] FIX_LO    = AW'(16'hE000);
  localparam logic [AW-1:0] VRAM_HI   = AW'(16'h5FFF);
  localparam logic [AW-1:0] PAL_LO    = AW'(16'h7100);
  localparam logic [AW-1:0] PAL_HI    = AW'(16'h73FF);

  logic [PW-1:0] page_q;

  wire rd_only = cpu_rd & ~cpu_wr;
  wire wr_only = cpu_wr & ~cpu_rd;
  wire [AW-1:0] port_idx = cpu_addr - PAGE_REG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      page_q <= '0;
    else if (wr_only && cpu_addr == PAGE_REG)
      page_q <= cpu_wdata[PW-1:0];

  always_comb begin
    rom_fixed_cs  = 1'b0;
    rom_bank_cs   = 1'b0;
    ram_rd_cs     = 1'b0;
    work_wr_cs    = 1'b0;
    obj_wr_cs     = 1'b0;
    bg_wr_cs      = 1'b0;
    port_rd_cs    = '0;
    hscroll_wr_cs = 1'b0;
    vscroll_wr_cs = 1'b0;
    sndcmd_wr_cs  = 1'b0;
    ctrl_pulse    = 1'b0;
    vram_wr_cs    = 1'b0;
    pal_wr_cs     = 1'b0;
    if (rd_only) begin
      if (cpu_addr <= RAM_TOP)
        ram_rd_cs = 1'b1;
      else if (cpu_addr >= PAGE_REG && cpu_addr <= PORT_TOP)
        port_rd_cs = NPORT'(1) << port_idx;
      else if (cpu_addr >= WIN_LO && cpu_addr <= WIN_HI)
        rom_bank_cs = 1'b1;
      else if (cpu_addr >= FIX_LO)
        rom_fixed_cs = 1'b1;
    end else if (wr_only) begin
      if (cpu_addr <= WORK_TOP)
        work_wr_cs = 1'b1;
      else if (cpu_addr <= OBJ_TOP)
        obj_wr_cs = 1'b1;
      else if (cpu_addr <= RAM_TOP)
        bg_wr_cs = 1'b1;
      else if (cpu_addr == CTRL_REG)
        ctrl_pulse = 1'b1;
      else if (cpu_addr == HS_LO || cpu_addr == HS_HI)
        hscroll_wr_cs = 1'b1;
      else if (cpu_addr == VS_LO || cpu_addr == VS_HI)
        vscroll_wr_cs = 1'b1;
      else if (cpu_addr == SND_REG)
        sndcmd_wr_cs = 1'b1;
      else if (cpu_addr >= WIN_LO && cpu_addr <= VRAM_HI)
        vram_wr_cs = 1'b1;
      else if (cpu_addr >= PAL_LO && cpu_addr <= PAL_HI)
        pal_wr_cs = 1'b1;
    end
  end

  wire [RW-1:0] bank_base = RW'(BANK_BASE) + RW'(page_q) * RW'(BANK_STRIDE);
  wire [RW-1:0] win_off   = RW'(cpu_addr - WIN_LO);

  assign rom_addr = rom_bank_cs ? bank_base + win_off : RW'(cpu_addr);

endmodule

module paged_map_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [3:0]  page_q,
  input logic [19:0] rom_addr,
  input logic        rom_fixed_cs,
  input logic        rom_bank_cs,
  input logic [4:0]  port_rd_cs,
  input logic [16:0] all_cs
);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_cs));

  // R10
  no_sel_bad_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd == cpu_wr) |-> all_cs == '0);

  // R4
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd && cpu_addr == 16'h4008) |=> page_q == $past(cpu_wdata[3:0]));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && !cpu_rd && cpu_addr == 16'h4008) |=> $stable(page_q));

  // R3
  bank_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank_cs |-> (rom_addr[11:0] == cpu_addr[11:0] && rom_addr >= 20'h10000));

  // R2
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_fixed_cs |-> rom_addr == {4'h0, cpu_addr});

  // R5
  port_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd_cs != '0) |-> (cpu_rd && $onehot(port_rd_cs)));

endmodule

bind paged_map_decoder paged_map_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .page_q(page_q), .rom_addr(rom_addr),
  .rom_fixed_cs(rom_fixed_cs), .rom_bank_cs(rom_bank_cs), .port_rd_cs(port_rd_cs),
  .all_cs({rom_fixed_cs, rom_bank_cs, ram_rd_cs, work_wr_cs, obj_wr_cs, bg_wr_cs,
           port_rd_cs, hscroll_wr_cs, vscroll_wr_cs, sndcmd_wr_cs, ctrl_pulse,
           vram_wr_cs, pal_wr_cs})
);

// File: tb/test_paged_map_decoder.sv
`timescale 1ns/1ps
module test_paged_map_decoder;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [19:0] rom_addr;
  logic rom_fixed_cs, rom_bank_cs, ram_rd_cs, work_wr_cs, obj_wr_cs, bg_wr_cs;
  logic [4:0] port_rd_cs;
  logic hscroll_wr_cs, vscroll_wr_cs, sndcmd_wr_cs, ctrl_pulse, vram_wr_cs, pal_wr_cs;

  int checks = 0, failures = 0, cycles = 0;
  int model_page = 0;
  bit done = 0;

  always #2 clk = ~clk;

  paged_map_decoder i_paged_map_decoder (.*);

  wire [16:0] got_cs = {rom_fixed_cs, rom_bank_cs, ram_rd_cs, work_wr_cs, obj_wr_cs, bg_wr_cs,
                        port_rd_cs, hscroll_wr_cs, vscroll_wr_cs, sndcmd_wr_cs, ctrl_pulse,
                        vram_wr_cs, pal_wr_cs};

  // Bit positions of got_cs, counted from the MSB.
  function automatic logic [16:0] cs_bit(int pos);
    return 17'h10000 >> pos;
  endfunction

  function automatic logic [16:0] exp_cs(int a, bit rd, bit wr);
    if (rd && !wr) begin
      if (a <= 'h3FFF) return cs_bit(2);
      if (a >= 'h4008 && a <= 'h400C) return cs_bit(6 + (4 - (a - 'h4008)));
      if (a >= 'h5000 && a <= 'hDFFF) return cs_bit(1);
      if (a >= 'hE000) return cs_bit(0);
    end else if (wr && !rd) begin
      if (a <= 'h1DFF) return cs_bit(3);
      if (a <= 'h1FFF) return cs_bit(4);
      if (a <= 'h3FFF) return cs_bit(5);
      if (a == 'h4009) return cs_bit(14);
      if (a == 'h400A || a == 'h400B) return cs_bit(11);
      if (a == 'h400C || a == 'h400D) return cs_bit(12);
      if (a == 'h400E) return cs_bit(13);
      if (a >= 'h5000 && a <= 'h5FFF) return cs_bit(15);
      if (a >= 'h7100 && a <= 'h73FF) return cs_bit(16);
    end
    return '0;
  endfunction

  function automatic string tag(int a, bit rd, bit wr);
    if (rd == wr) return "R10";
    if (rd) begin
      if (a <= 'h3FFF) return "R6";
      if (a >= 'h4008 && a <= 'h400C) return "R5";
      if (a >= 'h5000 && a <= 'hDFFF) return "R3";
      if (a >= 'hE000) return "R2";
      return "R10";
    end
    if (a <= 'h3FFF) return "R6";
    if (a == 'h4008) return "R4";
    if (a == 'h4009) return "R9";
    if (a >= 'h400A && a <= 'h400E) return "R7";
    if ((a >= 'h5000 && a <= 'h5FFF) || a >= 'h7100) return "R8";
    return "R10";
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%h expected=%h",
               req, cpu_addr, cpu_rd, cpu_wr, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_page = 0;
    else if (cpu_wr && !cpu_rd && cpu_addr == 16'h4008) model_page = cpu_wdata & 'hF;
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int a;
      logic [16:0] e;
      int ea;
      a = cpu_addr;
      e = exp_cs(a, cpu_rd, cpu_wr);
      ea = (e == cs_bit(1)) ? 'h10000 + model_page * 'h9000 + (a - 'h5000) : a;
      check(tag(a, cpu_rd, cpu_wr), got_cs, e);
      check((e == cs_bit(1)) ? "R3" : "R2", rom_addr, ea);
    end
  end

  task automatic drive(int a, bit rd, bit wr, int d);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'(d);
  endtask

  initial begin
    #50000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int corners[] = '{'h0000, 'h1DFF, 'h1E00, 'h1FFF, 'h2000, 'h3FFF, 'h4000, 'h4007,
                      'h4008, 'h4009, 'h400A, 'h400B, 'h400C, 'h400D, 'h400E, 'h400F,
                      'h4FFF, 'h5000, 'h5FFF, 'h6000, 'h70FF, 'h7100, 'h73FF, 'h7400,
                      'hDFFF, 'hE000, 'hFFFF};
    cpu_rd = 1; cpu_addr = 16'h5000;
    repeat (3) @(posedge clk);
    #1;
    check("R1", rom_addr, 'h10000);
    check("R1", rom_bank_cs, 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1", rom_addr, 'h10000);
    // R4: upper data bits ignored, effective next cycle
    drive('h4008, 0, 1, 'hF3);
    drive('hDFFF, 1, 0, 0);
    @(posedge clk); #1;
    check("R4", rom_addr, 'h33FFF);
    drive('h4008, 0, 1, 'h0F);
    drive('hDFFF, 1, 0, 0);
    @(posedge clk); #1;
    check("R3", rom_addr, 'h9FFFF);
    drive('h400C, 1, 0, 0);
    @(posedge clk); #1;
    check("R5", port_rd_cs, 5'b10000);
    drive('h4009, 0, 1, 0);
    @(posedge clk); #1;
    check("R9", ctrl_pulse, 1);
    drive('hFFFF, 0, 1, 0);
    @(posedge clk); #1;
    check("R8", got_cs, 0);
    for (int n = 0; n < 4000; n++) begin
      int a, s;
      bit rd, wr;
      s = $urandom_range(0, 9);
      a = (n % 2) ? corners[$urandom_range(0, corners.size() - 1)] : $urandom_range(0, 'hFFFF);
      rd = (s < 5); wr = (s >= 4 && s < 9);
      if (s == 9) begin rd = 0; wr = 0; end
      if (n % 50 == 0) begin a = 'h4008; rd = 0; wr = 1; end
      drive(a, rd, wr, $urandom_range(0, 255));
    end
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule